// File: doc/BRIEF.md
# Supply Monitor Reset Sequencer

This block turns a set of clean digital supervisor flags into the active-low reset level for a microcontroller. It watches a supply-above-threshold flag, an input-undervoltage flag, a supply-present flag and a watchdog reset request. Short dips on the supply flag are filtered out by a reaction-time counter that runs on the fast block clock. Any lasting fault pulls the reset low. Once every fault has cleared, a release delay counted in ticks of a prescaled clock keeps the reset low a while longer. The delay is twice as long in slow mode.

The output is a level plus an enable for the pin's pull-up. With no supply present the pull-up is switched off, so the reset pin floats. The block also gives a one-cycle pulse on the cycle the reset is released, so a watchdog can start its own timing there. All pins are plain control and status levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `supply_reset_seq`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0, `pullup_en` is 0 and `rel_pulse` is 0.
- R2: `sup_ok` low for `REACT_CYC` consecutive clock samples asserts reset. A dip of fewer samples leaves `rst_out_n` at 1.
- R3: With `mode_sel` equal to 2'b00 (fast), `rst_out_n` rises after `FAST_TICKS` tick cycles counted from the first cycle with no fault.
- R4: Any `mode_sel` value other than 2'b00 selects slow timing, a release delay of 2*`FAST_TICKS` ticks.
- R5: `in_uv` high forces `rst_out_n` low one cycle later, even while `sup_ok` is high.
- R6: `wdg_req` high forces `rst_out_n` low one cycle later. Release then follows the same delay as after power-up.
- R7: A fault that returns while a release is pending restarts the delay from zero.
- R8: `pullup_en` follows `sup_present` with one cycle of latency. `sup_present` low also forces reset.
- R9: `rel_pulse` is high for exactly one cycle, the first cycle in which `rst_out_n` is 1.
- R10: The release delay advances only in cycles where `tick` is 1.
- R11: `mode_sel` is sampled when the release delay starts. A change while the delay is pending does not alter that delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast block clock; it also paces the reaction filter |
| rst_n | input | 1 | Asynchronous active-low block reset |
| tick | input | 1 | One-cycle enable from the prescaled timebase |
| sup_ok | input | 1 | Output supply above its reset threshold |
| in_uv | input | 1 | Input supply under its own threshold |
| sup_present | input | 1 | Output supply above the minimum logic level |
| mode_sel | input | 2 | Timing select; 2'b00 is fast, any other value is slow |
| wdg_req | input | 1 | Reset request from the watchdog |
| rst_out_n | output | 1 | Reset level for the microcontroller, active low |
| pullup_en | output | 1 | Enable for the reset pin pull-up |
| rel_pulse | output | 1 | One-cycle pulse on reset release |

## Verification
The hardest situation to reach from the ports is the boundary of the reaction filter. Reset must be taken on a dip of exactly `REACT_CYC` samples and not on one a single sample shorter, so the bench sweeps every dip length around that edge and checks both outcomes. The second hard case is a restart in mid-delay. To reach it, the bench releases a watchdog request, waits part of the delay, pulses the request again, and then times the release from the second pulse. The bench freezes `tick` to show that only tick cycles advance the delay. It also changes `mode_sel` while a delay is pending to show that the mode is held.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } rsq_state_e;

  localparam logic [1:0] MODE_FAST = 2'b00;
endpackage

// File: rtl/rsq_dip_filter.sv
module rsq_dip_filter #(
  parameter int REACT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_ok,
  output logic lost
);
  localparam int W = $clog2(REACT_CYC + 1);
  localparam logic [W-1:0] TERM = W'(REACT_CYC);

  logic [W-1:0] low_cnt;

  // Starts saturated: after block reset the supply counts as lost until seen good.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= TERM;
    else if (sup_ok)         low_cnt <= '0;
    else if (low_cnt != TERM) low_cnt <= low_cnt + W'(1);
  end

  assign lost = (low_cnt == TERM);
endmodule

// File: rtl/rsq_release_timer.sv
module rsq_release_timer #(
  parameter int FAST_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic tick,
  input  logic slow,
  output logic done
);
  localparam int SLOW_TICKS = 2 * FAST_TICKS;
  localparam int W = $clog2(SLOW_TICKS + 1);
  localparam logic [W-1:0] LIM_FAST = W'(FAST_TICKS);
  localparam logic [W-1:0] LIM_SLOW = W'(SLOW_TICKS);

  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  assign done = active && tick && (cnt == lim - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lim <= LIM_FAST;
    end else if (arm) begin
      cnt <= '0;
      lim <= slow ? LIM_SLOW : LIM_FAST;
    end else if (active && tick && !done) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq
  import rsq_pkg::*;
#(
  parameter int REACT_CYC  = 8,
  parameter int FAST_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sup_ok,
  input  logic       in_uv,
  input  logic       sup_present,
  input  logic [1:0] mode_sel,
  input  logic       wdg_req,
  output logic       rst_out_n,
  output logic       pullup_en,
  output logic       rel_pulse
);
  rsq_state_e state, state_nx;
  logic lost, hold, done, pulse_q, pullup_q;

  rsq_dip_filter #(.REACT_CYC(REACT_CYC)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .sup_ok (sup_ok),
    .lost   (lost)
  );

  assign hold = lost | in_uv | wdg_req | ~sup_present;

  rsq_release_timer #(.FAST_TICKS(FAST_TICKS)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (state == ST_HOLD),
    .active ((state == ST_WAIT) && !hold),
    .tick   (tick),
    .slow   (mode_sel != MODE_FAST),
    .done   (done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_HOLD: state_nx = hold ? ST_HOLD : ST_WAIT;
      ST_WAIT: state_nx = hold ? ST_HOLD : (done ? ST_RUN : ST_WAIT);
      ST_RUN:  state_nx = hold ? ST_HOLD : ST_RUN;
      default: state_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_HOLD;
      pulse_q  <= 1'b0;
      pullup_q <= 1'b0;
    end else begin
      state    <= state_nx;
      pulse_q  <= (state == ST_WAIT) && (state_nx == ST_RUN);
      pullup_q <= sup_present;
    end
  end

  assign rst_out_n = (state == ST_RUN);
  assign rel_pulse = pulse_q;
  assign pullup_en = pullup_q;
endmodule

// File: rtl/supply_reset_seq_chk.sv
module supply_reset_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_uv,
  input logic sup_present,
  input logic wdg_req,
  input logic rst_out_n,
  input logic pullup_en,
  input logic rel_pulse
);
  p_fault_forces_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_uv || wdg_req || !sup_present) |=> !rst_out_n);   // R5, R6, R8

  p_pullup_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_present |=> !pullup_en);

  p_pulse_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> rel_pulse);

  p_pulse_only_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rel_pulse |-> (rst_out_n && !$past(rst_out_n)));

  p_release_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick));
endmodule

bind supply_reset_seq supply_reset_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .in_uv       (in_uv),
  .sup_present (sup_present),
  .wdg_req     (wdg_req),
  .rst_out_n   (rst_out_n),
  .pullup_en   (pullup_en),
  .rel_pulse   (rel_pulse)
);

// File: tb/supply_reset_seq_tb.sv
module supply_reset_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int REACT = 8;
  localparam int FAST  = 16;

  logic clk = 1'b0;
  logic rst_n, tick, sup_ok, in_uv, sup_present, wdg_req;
  logic [1:0] mode_sel;
  logic rst_out_n, pullup_en, rel_pulse;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_reset_seq #(.REACT_CYC(REACT), .FAST_TICKS(FAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sup_ok(sup_ok), .in_uv(in_uv),
    .sup_present(sup_present), .mode_sel(mode_sel), .wdg_req(wdg_req),
    .rst_out_n(rst_out_n), .pullup_en(pullup_en), .rel_pulse(rel_pulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges from now until rst_out_n is high; checks the release pulse.
  task automatic wait_rel(input string req, input int exp);
    int c = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      c++;
      if (rst_out_n) break;
    end
    chk(c == exp, req, c, exp);
    chk(rel_pulse == 1'b1, "R9 pulse at release", rel_pulse, 1);
    @(negedge clk);
    chk(rel_pulse == 1'b0 && rst_out_n == 1'b1, "R9 pulse one cycle", rel_pulse, 0);
  endtask

  task automatic wdg_kick();
    wdg_req = 1'b1;
    @(negedge clk);
    chk(rst_out_n == 1'b0, "R6 wdg forces low", rst_out_n, 0);
    wdg_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b1; sup_ok = 1'b0; in_uv = 1'b0;
    sup_present = 1'b1; wdg_req = 1'b0; mode_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rst_out_n == 1'b0, "R1 rst_out_n", rst_out_n, 0);
    chk(pullup_en == 1'b0, "R1 pullup_en", pullup_en, 0);
    chk(rel_pulse == 1'b0, "R1 rel_pulse", rel_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pullup_en == 1'b1, "R8 pullup follows", pullup_en, 1);
    // R3 power-up via sup_ok: filter clears one edge, then FAST ticks
    sup_ok = 1'b1;
    wait_rel("R3 fast power-up delay", FAST + 2);

    // R2 sweep of dip lengths around the reaction limit
    for (int n = 1; n <= REACT + 3; n++) begin
      sup_ok = 1'b0;
      repeat (n) @(negedge clk);
      sup_ok = 1'b1;
      if (n < REACT) begin
        repeat (3) @(negedge clk);
        chk(rst_out_n == 1'b1, "R2 short dip ignored", rst_out_n, 1);
      end else begin
        wait_rel("R2 long dip resets", FAST + 2);
      end
    end

    // R4 / R6 mode sweep through watchdog requests
    for (int m = 0; m < 4; m++) begin
      mode_sel = 2'(m);
      wdg_kick();
      if (m == 0) wait_rel("R6 wdg release fast", FAST + 1);
      else        wait_rel("R4 slow release", 2 * FAST + 1);
    end
    mode_sel = 2'b00;

    // R5 input undervoltage with good output supply
    in_uv = 1'b1;
    @(negedge clk);
    chk(rst_out_n == 1'b0, "R5 in_uv forces low", rst_out_n, 0);
    repeat (40) @(negedge clk);
    chk(rst_out_n == 1'b0, "R5 in_uv holds low", rst_out_n, 0);
    in_uv = 1'b0;
    wait_rel("R5 release after in_uv", FAST + 1);

    // R7 restart during pending release
    wdg_kick();
    repeat (10) @(negedge clk);
    chk(rst_out_n == 1'b0, "R7 still pending", rst_out_n, 0);
    wdg_kick();
    wait_rel("R7 restarted delay", FAST + 1);

    // R10 delay only advances on ticks
    tick = 1'b0;
    wdg_kick();
    repeat (100) @(negedge clk);
    chk(rst_out_n == 1'b0, "R10 no tick no release", rst_out_n, 0);
    tick = 1'b1;
    wait_rel("R10 ticks counted", FAST);

    // R11 mode change during pending delay ignored
    wdg_kick();
    begin
      int c = 0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        c++;
        if (c == 3) mode_sel = 2'b11;
        if (rst_out_n) break;
      end
      chk(c == FAST + 1, "R11 mode held", c, FAST + 1);
    end
    mode_sel = 2'b00;
    @(negedge clk);

    // R8 supply absent: pull-up off and reset low
    sup_present = 1'b0;
    @(negedge clk);
    chk(pullup_en == 1'b0, "R8 pullup off", pullup_en, 0);
    chk(rst_out_n == 1'b0, "R8 reset low", rst_out_n, 0);
    sup_present = 1'b1;
    wait_rel("R8 release after present", FAST + 1);
    chk(pullup_en == 1'b1, "R8 pullup back", pullup_en, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule